// File: doc/BRIEF.md
# Bootstrap Memory Copy Engine

This block keeps a small retained memory of 1024 bytes (256 dwords) that holds a bootstrap program. It copies a run of dwords from that memory into a processor's instruction memory through a plain synchronous write port. Software fills the retained memory and sets the copy parameters through a register port: a write strobe, a dword address, write data and registered read data. The parameters are a byte offset into the retained memory, a byte address in instruction memory and a dword count.

A copy starts in one of two ways. Software can write the go bit in the control word. Or a power-up pulse can arrive while the sticky auto-boot bit is set, which runs the same stored copy again with no software action. The go bit reads back as 1 while the copy runs and drops when it finishes, so software can poll it. A done flag in the status word reports completion.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset, the control word and status word read 0 and `imem_we` is 0.
- R2: A register-port address with bit 8 set selects bootstrap memory word `reg_addr[7:0]`. Writes store the data, and reads return it on `reg_rdata` one cycle after the address is presented.
- R3: Register indices 1 (source byte offset, 10 bits), 2 (destination byte address, 16 bits) and 3 (dword count, 16 bits) read back the value last written, including while a copy runs.
- R4: A running copy presents one write per cycle. Beat k has `imem_addr` = destination + 4k and `imem_wdata` = memory word (source/4 + k). The first beat appears in the cycle after the start edge.
- R5: Control word (index 0) bit 31 reads 1 from the start edge until the edge that issues the last beat, then reads 0. Status word (index 4) bit 0 is cleared by that start and set when the copy finishes.
- R6: A start with a count of 0 produces no write, leaves bit 31 at 0 and sets done at once.
- R7: The source word index wraps modulo 256, so a copy that runs past the end of the memory continues from word 0.
- R8: A start command, whether from software or from power-up, that arrives while a copy is running is ignored.
- R9: Control bit 30 is a sticky auto-boot enable that reads back. While it is 1, each `pwr_up` pulse starts a copy with the stored parameters. While it is 0, `pwr_up` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register-port write strobe |
| reg_addr | input | 9 | Dword address: bit 8 selects memory, otherwise a register index |
| reg_wdata | input | 32 | Register-port write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| pwr_up | input | 1 | Power-up event pulse |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_addr | output | 16 | Instruction memory byte address |
| imem_wdata | output | 32 | Instruction memory write data |

## Verification
The assertions check on every cycle that writes occur only while a copy is running and that back-to-back beats step the address by 4. They also check that running and done are never both set, that done clears when a copy starts, and that done is set when a copy ends. Only the bench scenarios can show the data values, the wrap of the source index, the zero-count case and the start commands that are ignored. The bench does this with a per-cycle model of the expected write stream and with register readback.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_SRC  = 1;
  localparam int unsigned IDX_DST  = 2;
  localparam int unsigned IDX_CNT  = 3;
  localparam int unsigned IDX_STAT = 4;
  localparam int unsigned BIT_GO   = 31;
  localparam int unsigned BIT_AUTO = 30;
  localparam int unsigned DW       = 32;
endpackage

// File: rtl/boot_ram.sv
module boot_ram #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [WORDS];

  // host port: write plus registered read
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  // engine port: registered read only
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/copy_seq.sv
module copy_seq #(
  parameter int WAW     = 8,
  parameter int IMEM_AW = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic [WAW-1:0]     src_word,
  input  logic [IMEM_AW-1:0] dst_addr,
  input  logic [CNT_W-1:0]   count,
  output logic               busy,
  output logic               done,
  output logic [WAW-1:0]     rd_word,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr
);
  logic [IMEM_AW-1:0] wr_ptr;
  logic [CNT_W-1:0]   left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_word   <= '0;
      wr_ptr    <= '0;
      left      <= '0;
      imem_we   <= 1'b0;
      imem_addr <= '0;
    end else begin
      imem_we <= 1'b0;
      if (busy) begin
        // RAM read of rd_word lands with this beat's address
        imem_we   <= 1'b1;
        imem_addr <= wr_ptr;
        wr_ptr    <= wr_ptr + IMEM_AW'(4);
        rd_word   <= rd_word + WAW'(1);
        left      <= left - CNT_W'(1);
        if (left == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (launch) begin
        busy    <= (count != '0);
        done    <= (count == '0);
        rd_word <= src_word;
        wr_ptr  <= dst_addr;
        left    <= count;
      end
    end
  end
endmodule

// File: rtl/copy_regs.sv
module copy_regs
  import boot_copy_pkg::*;
#(
  parameter int WAW     = 8,
  parameter int IMEM_AW = 16,
  parameter int CNT_W   = 16,
  localparam int MEM_AW = WAW + 2,
  localparam int ADDR_W = WAW + 1,
  localparam int HI_A   = (MEM_AW > IMEM_AW) ? MEM_AW : IMEM_AW,
  localparam int HI_USE = (HI_A > CNT_W) ? HI_A : CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  input  logic               busy,
  input  logic               done,
  input  logic [DW-1:0]      mem_q,
  output logic [DW-1:0]      rdata,
  output logic               mem_we,
  output logic               launch_sw,
  output logic               auto_en,
  output logic [WAW-1:0]     src_word,
  output logic [IMEM_AW-1:0] dst_addr,
  output logic [CNT_W-1:0]   count
);
  logic [MEM_AW-1:0] src_off;
  logic              mem_sel, reg_hit;
  logic [2:0]        idx;
  logic              sel_q;
  logic [DW-1:0]     reg_q, reg_mux;
  logic              unused_hi;

  assign unused_hi = ^wdata[BIT_AUTO-1:HI_USE];
  assign mem_sel   = addr[ADDR_W-1];
  assign idx       = addr[2:0];
  assign reg_hit   = !mem_sel && (addr[ADDR_W-2:3] == '0);
  assign mem_we    = we && mem_sel;
  assign launch_sw = we && reg_hit && (idx == 3'(IDX_CTRL)) && wdata[BIT_GO];
  assign src_word  = src_off[MEM_AW-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_en  <= 1'b0;
      src_off  <= '0;
      dst_addr <= '0;
      count    <= '0;
    end else if (we && reg_hit) begin
      case (idx)
        3'(IDX_CTRL): auto_en  <= wdata[BIT_AUTO];
        3'(IDX_SRC):  src_off  <= wdata[MEM_AW-1:0];
        3'(IDX_DST):  dst_addr <= wdata[IMEM_AW-1:0];
        3'(IDX_CNT):  count    <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_mux = '0;
    if (reg_hit) begin
      case (idx)
        3'(IDX_CTRL): begin
          reg_mux[BIT_GO]   = busy;
          reg_mux[BIT_AUTO] = auto_en;
        end
        3'(IDX_SRC):  reg_mux = DW'(src_off);
        3'(IDX_DST):  reg_mux = DW'(dst_addr);
        3'(IDX_CNT):  reg_mux = DW'(count);
        3'(IDX_STAT): reg_mux = DW'(done);
        default:      reg_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      reg_q <= '0;
    end else begin
      sel_q <= mem_sel;
      reg_q <= reg_mux;
    end
  end

  assign rdata = sel_q ? mem_q : reg_q;
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
  parameter int MEM_BYTES = 1024,
  parameter int IMEM_AW   = 16,
  parameter int CNT_W     = 16,
  localparam int WORDS    = MEM_BYTES / 4,
  localparam int WAW      = $clog2(WORDS),
  localparam int ADDR_W   = WAW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               pwr_up,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [31:0]        imem_wdata
);
  logic               busy, done, mem_we, launch_sw, auto_en, launch;
  logic [WAW-1:0]     src_word, rd_word;
  logic [IMEM_AW-1:0] dst_addr;
  logic [CNT_W-1:0]   count;
  logic [31:0]        mem_q;

  assign launch = launch_sw || (pwr_up && auto_en);

  copy_regs #(.WAW(WAW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .done(done), .mem_q(mem_q), .rdata(reg_rdata),
    .mem_we(mem_we), .launch_sw(launch_sw), .auto_en(auto_en),
    .src_word(src_word), .dst_addr(dst_addr), .count(count)
  );

  boot_ram #(.WORDS(WORDS), .DW(32)) u_ram (
    .clk(clk), .a_we(mem_we), .a_addr(reg_addr[WAW-1:0]), .a_wdata(reg_wdata),
    .a_rdata(mem_q), .b_addr(rd_word), .b_rdata(imem_wdata)
  );

  copy_seq #(.WAW(WAW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .src_word(src_word),
    .dst_addr(dst_addr), .count(count), .busy(busy), .done(done),
    .rd_word(rd_word), .imem_we(imem_we), .imem_addr(imem_addr)
  );
endmodule

// File: rtl/boot_copy_chk.sv
module boot_copy_chk #(
  parameter int IMEM_AW = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               imem_we,
  input logic [IMEM_AW-1:0] imem_addr
);
  // R4: a write beat only follows a cycle in which a copy was running
  a_r4_we_in_run: assert property (@(posedge clk) disable iff (rst)
    imem_we |-> $past(busy));
  // R4: consecutive beats step the byte address by 4
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (imem_we && $past(imem_we)) |-> (imem_addr == $past(imem_addr) + IMEM_AW'(4)));
  // R5: running and done are exclusive
  a_r5_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R5: starting a copy clears done
  a_r5_start_clr: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done);
  // R5: finishing a copy sets done
  a_r5_end_set: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind boot_copy_engine boot_copy_chk #(.IMEM_AW(IMEM_AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .imem_we(imem_we), .imem_addr(imem_addr)
);

// File: tb/tb_boot_copy_engine.sv
module tb_boot_copy_engine;
  localparam logic [8:0] A_CTRL = 9'd0, A_SRC = 9'd1, A_DST = 9'd2, A_CNT = 9'd3, A_STAT = 9'd4;

  logic clk = 0, rst = 1, reg_we = 0, pwr_up = 0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, imem_wdata;
  logic        imem_we;
  logic [15:0] imem_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  boot_copy_engine dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwr_up(pwr_up), .imem_we(imem_we),
    .imem_addr(imem_addr), .imem_wdata(imem_wdata)
  );

  // behavioural reference model
  logic [31:0] m_mem [256];
  logic [9:0]  m_src;
  logic [15:0] m_dst, m_cnt;
  bit m_auto, m_busy, m_done, m_we, pre_busy, pre_auto, trig;
  logic [15:0] m_addr;
  logic [31:0] m_data;
  logic [15:0] qa[$];
  logic [31:0] qd[$];

  always @(posedge clk) begin
    if (rst) begin
      m_src = 0; m_dst = 0; m_cnt = 0; m_auto = 0; m_busy = 0; m_done = 0; m_we = 0;
      qa.delete(); qd.delete();
    end else begin
      pre_busy = m_busy; pre_auto = m_auto;
      m_we = 0;
      if (qa.size() > 0) begin
        m_we = 1; m_addr = qa.pop_front(); m_data = qd.pop_front();
        if (qa.size() == 0) begin m_busy = 0; m_done = 1; end
      end
      trig = (reg_we && reg_addr == A_CTRL && reg_wdata[31]) || (pwr_up && pre_auto);
      if (trig && !pre_busy) begin
        if (m_cnt == 0) m_done = 1;
        else begin
          m_done = 0; m_busy = 1;
          for (int k = 0; k < int'(m_cnt); k++) begin
            qa.push_back(m_dst + 16'(4 * k));
            qd.push_back(m_mem[(int'(m_src) / 4 + k) % 256]);
          end
        end
      end
      if (reg_we) begin
        if (reg_addr[8]) m_mem[reg_addr[7:0]] = reg_wdata;
        else case (reg_addr)
          A_CTRL: m_auto = reg_wdata[30];
          A_SRC:  m_src  = reg_wdata[9:0];
          A_DST:  m_dst  = reg_wdata[15:0];
          A_CNT:  m_cnt  = reg_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle compare of the write stream (R4, R7, R8, R9)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R4 imem_we", 32'(imem_we), 32'(m_we));
      if (m_we && imem_we) begin
        check("R4 imem_addr", 32'(imem_addr), 32'(m_addr));
        check("R4 imem_wdata", imem_wdata, m_data);
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); reg_we = 0; reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); pwr_up = 1;
    @(negedge clk); pwr_up = 0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    v = 32'hFFFF_FFFF;
    for (int i = 0; i < 1000; i++) begin
      rd(A_CTRL, v);
      if (!v[31]) break;
    end
    check(req, 32'(v[31]), 32'd0);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101) ^ (32'(i) << 20);
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 imem_we", 32'(imem_we), 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    // R6 zero count
    wr(A_CNT, 0);
    wr(A_CTRL, 32'h8000_0000);
    rd(A_STAT, v); check("R6 done", v, 1);
    rd(A_CTRL, v); check("R6 go clear", v, 0);
    // R2 memory load and readback
    for (int i = 0; i < 256; i++) wr(9'h100 | 9'(i), pat(i));
    rd(9'h100, v); check("R2 word0", v, pat(0));
    rd(9'h17F, v); check("R2 word127", v, pat(127));
    rd(9'h1FF, v); check("R2 word255", v, pat(255));
    // R3 config regs
    wr(A_SRC, 32'h10); wr(A_DST, 32'h200); wr(A_CNT, 8);
    rd(A_SRC, v); check("R3 src", v, 32'h10);
    rd(A_DST, v); check("R3 dst", v, 32'h200);
    rd(A_CNT, v); check("R3 cnt", v, 8);
    // R4/R5 software copy
    wr(A_CTRL, 32'h8000_0000);
    rd(A_CTRL, v); check("R5 go while running", v, 32'h8000_0000);
    rd(A_STAT, v); check("R5 done cleared", v, 0);
    wait_idle("R5 go clears");
    rd(A_STAT, v); check("R5 done set", v, 1);
    // R8 start during run ignored
    wr(A_SRC, 0); wr(A_DST, 32'h100); wr(A_CNT, 20);
    wr(A_CTRL, 32'h8000_0000);
    wr(A_SRC, 32'h40);
    wr(A_CTRL, 32'h8000_0000);
    rd(A_SRC, v); check("R3 src during run", v, 32'h40);
    wait_idle("R8 idle");
    // R7 wrap
    wr(A_SRC, 32'h3F0); wr(A_DST, 32'h1000); wr(A_CNT, 10);
    wr(A_CTRL, 32'h8000_0000);
    wait_idle("R7 idle");
    rd(A_STAT, v); check("R7 done", v, 1);
    // R9 auto-boot
    pulse();
    rd(A_CTRL, v); check("R9 pwr_up ignored without enable", v, 0);
    wr(A_SRC, 32'h20); wr(A_DST, 32'h800); wr(A_CNT, 6);
    wr(A_CTRL, 32'h4000_0000);
    rd(A_CTRL, v); check("R9 auto readback", v, 32'h4000_0000);
    pulse();
    rd(A_CTRL, v); check("R9 pwr_up starts", v, 32'hC000_0000);
    pulse(); // R8: ignored while running
    wait_idle("R9 idle");
    rd(A_STAT, v); check("R9 done", v, 1);
    pulse();
    rd(A_CTRL, v); check("R9 re-arm", v, 32'hC000_0000);
    wait_idle("R9 idle again");
    rd(A_CTRL, v); check("R9 auto sticky", v, 32'h4000_0000);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule